// File: doc/BRIEF.md
# Dual Wiper Register Instruction Engine

This block holds the digital state of two 64-position digital potentiometers and carries out register instructions that an upstream serial front end has already decoded into fields. Each pot has one volatile wiper register and four saved-position slots. All registers are 6 bits wide. The block takes a 4-bit instruction code, a slot select, a pot select and a data byte. It can write and read any register, copy between a pot's wiper and its slots, move a saved slot into both wipers at once, save both wipers at once, and step a wiper up or down by one.

Two resets are provided. The cold reset `por` stands for the first power-up of a blank part and clears everything. The warm reset `rst` stands for a later power cycle. It keeps the saved slots and reloads each wiper from its slot 0. The only analog-facing outputs are the two 6-bit tap indices. Reads come back one cycle after the instruction, as a registered byte with a valid strobe.

Top module: `potreg_engine`

## Requirements
- R1: While `por` is high at a clock edge, every wiper and every slot of both pots becomes 0, stepping is disarmed and `rd_valid` is 0.
- R2: A clock edge with `rst` high (and `por` low) loads each pot's wiper from that pot's slot 0, leaves all slots unchanged, disarms stepping and drives `rd_valid` to 0.
- R3: Code 4'b1010 writes `cmd_data[5:0]` into the wiper of the pot given by `cmd_pot`; `cmd_data[7:6]` are ignored.
- R4: Code 4'b1001 (wiper of `cmd_pot`) and code 4'b1011 (slot `cmd_sel` of `cmd_pot`) raise `rd_valid` for exactly the following cycle. In that cycle `rd_data` holds the 6-bit value in bits 5:0, with bits 7:6 at 0.
- R5: Code 4'b1100 writes `cmd_data[5:0]` into slot `cmd_sel` of pot `cmd_pot`; no other register changes.
- R6: Code 4'b1101 copies slot `cmd_sel` of pot `cmd_pot` into that pot's wiper. Code 4'b1110 copies that pot's wiper into its slot `cmd_sel`.
- R7: Code 4'b0001 loads each pot's wiper from its own slot `cmd_sel` in the same cycle; `cmd_pot` is ignored.
- R8: Code 4'b1000 saves each pot's wiper into its own slot `cmd_sel` in the same cycle; `cmd_pot` is ignored.
- R9: Code 4'b0010 arms stepping for pot `cmd_pot`. While stepping is armed and `cmd_valid` is low, each cycle with `step_valid` high moves that pot's wiper by one: up when `step_up` is 1, down when it is 0. Any accepted instruction disarms stepping and takes priority over a step in the same cycle. A step while stepping is disarmed has no effect.
- R10: Stepping saturates. A step up at 63 leaves 63 and a step down at 0 leaves 0.
- R11: Any code not listed above changes no register, and no read data is returned for it.
- R12: `taps[5:0]` is the wiper of pot 0 and `taps[11:6]` is the wiper of pot 1, each updating on the clock edge that accepts the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Warm reset, synchronous active-high: recall slot 0 into wipers |
| por | input | 1 | Cold reset, synchronous active-high: clear all registers |
| cmd_valid | input | 1 | Instruction present this cycle |
| cmd_op | input | 4 | Instruction code |
| cmd_sel | input | 2 | Slot select |
| cmd_pot | input | 1 | Pot select |
| cmd_data | input | 8 | Write data byte |
| step_valid | input | 1 | One step request |
| step_up | input | 1 | Step direction, 1 = up |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data, zero-extended |
| taps | output | 12 | Tap index of both pots |

## Verification
The bench builds the block with the package defaults: 6-bit taps, four slots per pot and two pots. With these values, 64 consecutive steps take a wiper from 0 past the upper limit, so saturation at both ends is reached within a short directed run. Every slot of both pots is addressable by explicit writes, so retention across a warm reset can be checked slot by slot. A long pseudo-random stretch mixes every code, including the unused ones, with stray steps and occasional warm resets. An independent per-cycle model follows this stretch.

// File: rtl/potreg_pkg.sv
package potreg_pkg;
    localparam int TAP_W  = 6;
    localparam int SLOT_N = 4;
    localparam int CH_N   = 2;
    localparam int BYTE_W = 8;
    localparam int SLOT_W = $clog2(SLOT_N);
    localparam int POT_W  = $clog2(CH_N);
    localparam int OP_W   = 4;

    typedef logic [TAP_W-1:0] tap_t;
    localparam tap_t TAP_MAX = '1;
    localparam tap_t TAP_MIN = '0;

    localparam logic [OP_W-1:0] OP_GLOAD = 4'b0001;
    localparam logic [OP_W-1:0] OP_ARM   = 4'b0010;
    localparam logic [OP_W-1:0] OP_GSAVE = 4'b1000;
    localparam logic [OP_W-1:0] OP_RDW   = 4'b1001;
    localparam logic [OP_W-1:0] OP_WRW   = 4'b1010;
    localparam logic [OP_W-1:0] OP_RDS   = 4'b1011;
    localparam logic [OP_W-1:0] OP_WRS   = 4'b1100;
    localparam logic [OP_W-1:0] OP_S2W   = 4'b1101;
    localparam logic [OP_W-1:0] OP_W2S   = 4'b1110;

    typedef enum logic [2:0] {
        ACT_IDLE, ACT_W_LOAD, ACT_S_LOAD, ACT_W_RECALL,
        ACT_S_SAVE, ACT_STEP_UP, ACT_STEP_DN
    } act_e;

    typedef struct packed {
        act_e              kind;
        logic [SLOT_W-1:0] slot;
        tap_t              val;
    } chan_cmd_t;

    typedef struct packed {
        logic              req;
        logic              from_slot;
        logic [POT_W-1:0]  pot;
        logic [SLOT_W-1:0] slot;
    } rd_req_t;

    function automatic tap_t step_sat(tap_t v, logic up);
        if (up)  return (v == TAP_MAX) ? v : v + tap_t'(1);
        else     return (v == TAP_MIN) ? v : v - tap_t'(1);
    endfunction

    function automatic logic op_known(logic [OP_W-1:0] op);
        return op inside {OP_GLOAD, OP_ARM, OP_GSAVE, OP_RDW, OP_WRW,
                          OP_RDS, OP_WRS, OP_S2W, OP_W2S};
    endfunction
endpackage

// File: rtl/potreg_decode.sv
module potreg_decode
    import potreg_pkg::*;
(
    input  logic                  cmd_valid,
    input  logic [OP_W-1:0]       cmd_op,
    input  logic [SLOT_W-1:0]     cmd_sel,
    input  logic [POT_W-1:0]      cmd_pot,
    input  logic [BYTE_W-1:0]     cmd_data,
    input  logic                  step_valid,
    input  logic                  step_up,
    input  logic                  armed,
    input  logic [POT_W-1:0]      arm_pot,
    output chan_cmd_t             acts [CH_N],
    output rd_req_t               rd,
    output logic                  arm_set
);
    always_comb begin
        for (int c = 0; c < CH_N; c++) begin
            acts[c].kind = ACT_IDLE;
            acts[c].slot = cmd_sel;
            acts[c].val  = cmd_data[TAP_W-1:0];
        end
        rd      = '0;
        arm_set = 1'b0;
        if (cmd_valid) begin
            case (cmd_op)
                OP_GLOAD: for (int c = 0; c < CH_N; c++) acts[c].kind = ACT_W_RECALL;
                OP_GSAVE: for (int c = 0; c < CH_N; c++) acts[c].kind = ACT_S_SAVE;
                OP_ARM:   arm_set = 1'b1;
                OP_RDW: begin
                    rd.req = 1'b1; rd.from_slot = 1'b0; rd.pot = cmd_pot; rd.slot = cmd_sel;
                end
                OP_RDS: begin
                    rd.req = 1'b1; rd.from_slot = 1'b1; rd.pot = cmd_pot; rd.slot = cmd_sel;
                end
                OP_WRW:   acts[cmd_pot].kind = ACT_W_LOAD;
                OP_WRS:   acts[cmd_pot].kind = ACT_S_LOAD;
                OP_S2W:   acts[cmd_pot].kind = ACT_W_RECALL;
                OP_W2S:   acts[cmd_pot].kind = ACT_S_SAVE;
                default:  ;
            endcase
        end else if (step_valid && armed) begin
            acts[arm_pot].kind = step_up ? ACT_STEP_UP : ACT_STEP_DN;
        end
    end
endmodule

// File: rtl/potreg_channel.sv
module potreg_channel
    import potreg_pkg::*;
(
    input  logic      clk,
    input  logic      por,
    input  logic      rst,
    input  chan_cmd_t cmd,
    output tap_t      wiper,
    output tap_t      slots [SLOT_N]
);
    tap_t wiper_q;
    tap_t slot_q [SLOT_N];

    always_ff @(posedge clk) begin
        if (por) begin
            wiper_q <= '0;
            for (int i = 0; i < SLOT_N; i++) slot_q[i] <= '0;
        end else if (rst) begin
            wiper_q <= slot_q[0];
        end else begin
            case (cmd.kind)
                ACT_W_LOAD:   wiper_q          <= cmd.val;
                ACT_S_LOAD:   slot_q[cmd.slot] <= cmd.val;
                ACT_W_RECALL: wiper_q          <= slot_q[cmd.slot];
                ACT_S_SAVE:   slot_q[cmd.slot] <= wiper_q;
                ACT_STEP_UP:  wiper_q          <= step_sat(wiper_q, 1'b1);
                ACT_STEP_DN:  wiper_q          <= step_sat(wiper_q, 1'b0);
                default:      ;
            endcase
        end
    end

    assign wiper = wiper_q;
    assign slots = slot_q;

    // R10
    sat_hi_chk: assert property (@(posedge clk) disable iff (por || rst)
        (cmd.kind == ACT_STEP_UP && wiper_q == TAP_MAX) |=> wiper_q == TAP_MAX);
    // R10
    sat_lo_chk: assert property (@(posedge clk) disable iff (por || rst)
        (cmd.kind == ACT_STEP_DN && wiper_q == TAP_MIN) |=> wiper_q == TAP_MIN);
    // R9
    step_one_chk: assert property (@(posedge clk) disable iff (por || rst)
        (cmd.kind == ACT_STEP_UP && wiper_q != TAP_MAX) |=> wiper_q == $past(wiper_q) + tap_t'(1));
    // R2
    recall_chk: assert property (@(posedge clk) disable iff (por)
        rst |=> wiper_q == $past(slot_q[0]));

    for (genvar i = 0; i < SLOT_N; i++) begin : g_keep
        // R2
        retain_chk: assert property (@(posedge clk) disable iff (por)
            rst |=> $stable(slot_q[i]));
    end
endmodule

// File: rtl/potreg_engine.sv
module potreg_engine
    import potreg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    por,
    input  logic                    cmd_valid,
    input  logic [OP_W-1:0]         cmd_op,
    input  logic [SLOT_W-1:0]       cmd_sel,
    input  logic [POT_W-1:0]        cmd_pot,
    input  logic [BYTE_W-1:0]       cmd_data,
    input  logic                    step_valid,
    input  logic                    step_up,
    output logic                    rd_valid,
    output logic [BYTE_W-1:0]       rd_data,
    output logic [CH_N*TAP_W-1:0]   taps
);
    chan_cmd_t        acts [CH_N];
    rd_req_t          rd;
    logic             arm_set;
    logic             armed_q;
    logic [POT_W-1:0] arm_pot_q;
    tap_t             wiper_w [CH_N];
    tap_t             slot_w  [CH_N][SLOT_N];
    tap_t             rd_val;

    potreg_decode u_dec (
        .cmd_valid (cmd_valid), .cmd_op (cmd_op), .cmd_sel (cmd_sel),
        .cmd_pot (cmd_pot), .cmd_data (cmd_data), .step_valid (step_valid),
        .step_up (step_up), .armed (armed_q), .arm_pot (arm_pot_q),
        .acts (acts), .rd (rd), .arm_set (arm_set)
    );

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        potreg_channel u_ch (
            .clk (clk), .por (por), .rst (rst), .cmd (acts[c]),
            .wiper (wiper_w[c]), .slots (slot_w[c])
        );
        assign taps[c*TAP_W +: TAP_W] = wiper_w[c];
    end

    always_ff @(posedge clk) begin
        if (por || rst) begin
            armed_q   <= 1'b0;
            arm_pot_q <= '0;
        end else if (arm_set) begin
            armed_q   <= 1'b1;
            arm_pot_q <= cmd_pot;
        end else if (cmd_valid) begin
            armed_q   <= 1'b0;
        end
    end

    assign rd_val = rd.from_slot ? slot_w[rd.pot][rd.slot] : wiper_w[rd.pot];

    always_ff @(posedge clk) begin
        if (por || rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd.req;
            rd_data  <= {{(BYTE_W-TAP_W){1'b0}}, rd_val};
        end
    end

    // R11
    unknown_op_chk: assert property (@(posedge clk) disable iff (por || rst)
        (cmd_valid && !op_known(cmd_op)) |=> ($stable(taps) && !rd_valid));
    // R9
    disarmed_step_chk: assert property (@(posedge clk) disable iff (por || rst)
        (step_valid && !cmd_valid && !armed_q) |=> $stable(taps));
    // R4
    read_strobe_chk: assert property (@(posedge clk) disable iff (por || rst)
        (cmd_valid && (cmd_op == OP_RDW || cmd_op == OP_RDS)) |=> rd_valid);
    // R1
    cold_clear_chk: assert property (@(posedge clk)
        por |=> (taps == '0 && !rd_valid));
endmodule

// File: tb/tb_potreg_engine.sv
module tb_potreg_engine;
    logic       clk = 1'b0;
    logic       rst = 1'b0, por = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_op = '0;
    logic [1:0] cmd_sel = '0;
    logic       cmd_pot = 1'b0;
    logic [7:0] cmd_data = '0;
    logic       step_valid = 1'b0, step_up = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic [11:0] taps;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 0;

    int    mw [2];
    int    md [2][4];
    bit    m_rdv;
    int    m_rdd;
    bit    marm;
    int    mapot;
    string tag = "R1";

    always #2.5 clk = ~clk;

    potreg_engine dut (
        .clk, .rst, .por, .cmd_valid, .cmd_op, .cmd_sel, .cmd_pot, .cmd_data,
        .step_valid, .step_up, .rd_valid, .rd_data, .taps
    );

    // behavioural reference, updated on each edge
    always @(posedge clk) begin
        cycles++;
        if (por) begin
            foreach (mw[c]) begin mw[c] = 0; for (int s = 0; s < 4; s++) md[c][s] = 0; end
            m_rdv = 0; m_rdd = 0; marm = 0; mapot = 0; tag = "R1";
        end else if (rst) begin
            foreach (mw[c]) mw[c] = md[c][0];
            m_rdv = 0; m_rdd = 0; marm = 0; tag = "R2";
        end else begin
            m_rdv = 0;
            if (cmd_valid) begin
                marm = 0;
                case (cmd_op)
                    4'b1010: begin mw[cmd_pot] = cmd_data % 64; tag = "R3"; end
                    4'b1001: begin m_rdv = 1; m_rdd = mw[cmd_pot]; tag = "R4"; end
                    4'b1011: begin m_rdv = 1; m_rdd = md[cmd_pot][cmd_sel]; tag = "R4"; end
                    4'b1100: begin md[cmd_pot][cmd_sel] = cmd_data % 64; tag = "R5"; end
                    4'b1101: begin mw[cmd_pot] = md[cmd_pot][cmd_sel]; tag = "R6"; end
                    4'b1110: begin md[cmd_pot][cmd_sel] = mw[cmd_pot]; tag = "R6"; end
                    4'b0001: begin foreach (mw[c]) mw[c] = md[c][cmd_sel]; tag = "R7"; end
                    4'b1000: begin foreach (mw[c]) md[c][cmd_sel] = mw[c]; tag = "R8"; end
                    4'b0010: begin marm = 1; mapot = cmd_pot; tag = "R9"; end
                    default: tag = "R11";
                endcase
            end else if (step_valid && marm) begin
                if (step_up && mw[mapot] < 63) mw[mapot]++;
                else if (!step_up && mw[mapot] > 0) mw[mapot]--;
                tag = (mw[mapot] == 0 || mw[mapot] == 63) ? "R10" : "R9";
            end
        end
    end

    task automatic chk(int act, int exp, string req);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (cycles > 0 && !done) begin
            chk(int'(taps[5:0]),  mw[0], {tag, "/R12 pot0"});
            chk(int'(taps[11:6]), mw[1], {tag, "/R12 pot1"});
            chk(int'(rd_valid), int'(m_rdv), {tag, " rd_valid"});
            if (m_rdv) chk(int'(rd_data), m_rdd, {tag, " rd_data"});
        end
    end

    task automatic issue(logic [3:0] op, logic [1:0] sel, logic pot, logic [7:0] d);
        cmd_valid = 1; cmd_op = op; cmd_sel = sel; cmd_pot = pot; cmd_data = d;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic step(logic up);
        step_valid = 1; step_up = up;
        @(negedge clk);
        step_valid = 0;
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        chk(int'(taps), 0, "R1 reset taps");
        chk(int'(rd_valid), 0, "R1 reset rd_valid");
        por = 0;
        // fill slots; top bits of data must be dropped
        issue(4'b1100, 2'd0, 1'b0, 8'hD1);   // 17
        issue(4'b1100, 2'd0, 1'b1, 8'h2A);   // 42
        for (int s = 1; s < 4; s++) begin
            issue(4'b1100, 2'(s), 1'b0, 8'(10 + s));
            issue(4'b1100, 2'(s), 1'b1, 8'(50 + s));
        end
        rst = 1; @(negedge clk); rst = 0;
        chk(int'(taps[5:0]), 17, "R2 recall pot0");
        chk(int'(taps[11:6]), 42, "R2 recall pot1");
        issue(4'b1011, 2'd2, 1'b1, 8'h00);
        chk(int'(rd_data), 52, "R2 slot kept / R4 read slot");
        issue(4'b1010, 2'd0, 1'b0, 8'hFF);
        chk(int'(taps[5:0]), 63, "R3 write wiper");
        issue(4'b1001, 2'd0, 1'b0, 8'h00);
        chk(int'(rd_data), 63, "R4 read wiper zero-extended");
        @(negedge clk);
        chk(int'(rd_valid), 0, "R4 single strobe");
        issue(4'b1101, 2'd3, 1'b1, 8'h00);
        chk(int'(taps[11:6]), 53, "R6 slot to wiper");
        issue(4'b1110, 2'd1, 1'b0, 8'h00);
        issue(4'b1011, 2'd1, 1'b0, 8'h00);
        chk(int'(rd_data), 63, "R6 wiper to slot");
        issue(4'b0001, 2'd2, 1'b1, 8'h00);
        chk(int'(taps), (52 << 6) | 12, "R7 global load");
        issue(4'b1010, 2'd0, 1'b1, 8'h05);
        issue(4'b1000, 2'd3, 1'b0, 8'h00);
        issue(4'b1011, 2'd3, 1'b1, 8'h00);
        chk(int'(rd_data), 5, "R8 global save");
        // stepping
        step(1'b1);
        chk(int'(taps[11:6]), 5, "R9 step ignored while disarmed");
        issue(4'b0010, 2'd0, 1'b1, 8'h00);
        for (int i = 0; i < 70; i++) step(1'b1);
        chk(int'(taps[11:6]), 63, "R10 saturate high");
        chk(int'(taps[5:0]), 12, "R9 other pot untouched");
        for (int i = 0; i < 70; i++) step(1'b0);
        chk(int'(taps[11:6]), 0, "R10 saturate low");
        step_valid = 1; step_up = 1;
        issue(4'b1001, 2'd0, 1'b1, 8'h00);
        step_valid = 0;
        chk(int'(taps[11:6]), 0, "R9 command wins over step");
        step(1'b1);
        chk(int'(taps[11:6]), 0, "R9 command disarmed stepping");
        // unused codes
        foreach (taps[i]) if (i < 8) begin end
        for (int op = 0; op < 16; op++) begin
            if (!(op inside {1, 2, 8, 9, 10, 11, 12, 13, 14})) begin
                issue(4'(op), 2'd1, 1'b0, 8'h3F);
                chk(int'(taps), 12, "R11 unused code");
            end
        end
        // pseudo-random mix
        begin
            logic [31:0] lf = 32'hACE1_2468;
            for (int n = 0; n < 3000; n++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                cmd_valid  = lf[0] & lf[9];
                cmd_op     = lf[7:4];
                cmd_sel    = lf[11:10];
                cmd_pot    = lf[12];
                cmd_data   = lf[23:16];
                step_valid = lf[13];
                step_up    = lf[14] | lf[15];
                rst        = (lf[29:24] == 6'h2A);
                @(negedge clk);
            end
            cmd_valid = 0; step_valid = 0; rst = 0;
        end
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        if (cycles > 20000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule